// File: doc/BRIEF.md
# Binary64 Rounding and Exponent Range Stage

This block is the last step of a double-precision arithmetic datapath. It takes an unrounded result made of a sign, a signed biased exponent, a 53-bit mantissa with the leading one at the top, and the guard and sticky bits left over from the operation. From these it produces the packed binary64 word. It applies one of four rounding directions. It detects overflow and underflow of the exponent range. It reports inexact, overflow and underflow either as status flags or, when the matching trap enable is set, as bits of a trap code.

When an overflow or underflow is trapped, the block does not saturate or flush the result. It returns the rounded value with its exponent moved back into range by three quarters of the exponent span. When an underflow is not trapped, the value is shifted right into subnormal form and rounded a second time. Tininess is judged after rounding, so a value that would round up to the smallest normal number raises no underflow flag.

The stage is combinational by default. The parameter `OUT_REG` adds one output register stage with an asynchronous active-low reset.

Top module: `fp_round_range`

## Requirements
- R1: Rounding mode encoding is 0 toward zero, 1 nearest-even, 2 toward +infinity, 3 toward -infinity. Toward zero never increments the mantissa.
- R2: Nearest-even increments only when the guard bit is set and either the sticky bit or the mantissa LSB is set.
- R3: Toward +infinity increments only for a positive inexact value. Toward -infinity increments only for a negative inexact value.
- R4: A rounding carry out of the 53-bit mantissa adds one to the exponent and leaves a zero fraction. This carry can push the result into overflow.
- R5: `result` is packed as {sign, exponent[10:0], fraction[51:0]}, and `mant_in[52]` is the hidden bit. An exact in-range input passes through unchanged, with no flag and no trap code.
- R6: Untrapped overflow (rounded exponent at or above 2047) sets the overflow flag and reports inexact. The result is infinity for nearest, for +infinity on a positive value and for -infinity on a negative value; in every other case it is the largest finite number of the result's sign.
- R7: Trapped overflow returns the rounded value with 1536 subtracted from its exponent and sets trap code bit 2. The overflow flag stays clear.
- R8: With the underflow trap enabled, rounding is applied even for an exponent at or below zero. A rounded exponent at or below zero then gets 1536 added and sets trap code bit 1.
- R9: Untrapped underflow shifts the mantissa right by 1 minus the exponent. The last bit shifted out becomes the new guard. All other lost bits and the incoming guard and sticky bits form the new sticky. The value is then rounded again in the selected mode.
- R10: For an incoming exponent of exactly zero, an inexact value whose trial rounding would carry out of the mantissa is not tiny and raises no underflow flag.
- R11: The underflow flag is set only when the result is tiny and the denormalized result is inexact. An exact subnormal raises no flag.
- R12: Inexact is reported in trap code bit 0 when its trap is enabled and in `inx_flag` otherwise, never both. This applies to normal, overflow and underflow results alike.
- R13: With `OUT_REG`=1, outputs follow the inputs one clock later, and reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_in | input | 1 | Sign of the unrounded value |
| exp_in | input | EXP_W+3 | Signed biased exponent |
| mant_in | input | FRAC_W+1 | Mantissa, hidden bit at the top |
| guard_in | input | 1 | First bit below the mantissa LSB |
| sticky_in | input | 1 | OR of all lower bits |
| rmode | input | 2 | Rounding direction (R1 encoding) |
| ovf_trap_en | input | 1 | Overflow trap enable |
| unf_trap_en | input | 1 | Underflow trap enable |
| inx_trap_en | input | 1 | Inexact trap enable |
| result | output | EXP_W+FRAC_W+1 | Packed floating-point result |
| ovf_flag | output | 1 | Untrapped overflow occurred |
| unf_flag | output | 1 | Untrapped tiny and inexact result |
| inx_flag | output | 1 | Untrapped inexact result |
| trap_code | output | 3 | Trapped events: bit 2 overflow, bit 1 underflow, bit 0 inexact |

## Verification
The bench builds the block with `OUT_REG`=1 and the default binary64 widths (11-bit exponent, 52-bit fraction). The register stage brings the reset value and the one-cycle latency within reach of the checks. The real field widths allow the vectors to use exact bit patterns for the carry into the exponent, the largest finite number and the 1536 exponent wrap. They also cover shift distances of 1, 52 and 53, a shift beyond the clamp, and the all-ones mantissa at exponent zero that separates tininess before rounding from tininess after it.

// File: rtl/fp_round_range.sv
module fp_round_range #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sign_in,
  input  logic signed [EXP_W+2:0]     exp_in,
  input  logic [FRAC_W:0]             mant_in,
  input  logic                        guard_in,
  input  logic                        sticky_in,
  input  logic [1:0]                  rmode,
  input  logic                        ovf_trap_en,
  input  logic                        unf_trap_en,
  input  logic                        inx_trap_en,
  output logic [EXP_W+FRAC_W:0]       result,
  output logic                        ovf_flag,
  output logic                        unf_flag,
  output logic                        inx_flag,
  output logic [2:0]                  trap_code
);
  localparam int MW    = FRAC_W + 1;
  localparam int EW    = EXP_W + 3;
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int SHMAX = MW + 2;
  localparam int SHW   = $clog2(SHMAX + 1);
  localparam logic signed [EW-1:0] EMAX  = EW'((1 << EXP_W) - 1);
  localparam logic signed [EW-1:0] WRAP  = EW'(3 << (EXP_W - 2));
  localparam logic signed [EW-1:0] ZERO  = '0;
  localparam logic signed [EW-1:0] ONE   = EW'(1);
  localparam logic signed [EW-1:0] SHLIM = EW'(SHMAX);
  localparam logic [1:0] RM_RN = 2'd1, RM_RP = 2'd2, RM_RM = 2'd3;

  function automatic logic want_inc(input logic [1:0] rm, input logic sg,
                                    input logic gb, input logic sb, input logic lsb);
    case (rm)
      RM_RN:   return gb & (sb | lsb);
      RM_RP:   return ~sg & (gb | sb);
      RM_RM:   return sg & (gb | sb);
      default: return 1'b0;
    endcase
  endfunction

  // first rounding at full precision
  logic inx0, do_rnd, inc0, carry;
  logic [MW:0] m_sum;
  logic [FRAC_W-1:0] frac_r;
  logic signed [EW-1:0] e_r, e_wo, e_wu;

  assign inx0   = guard_in | sticky_in;
  assign do_rnd = inx0 & ((exp_in > ZERO) | unf_trap_en);
  assign inc0   = do_rnd & want_inc(rmode, sign_in, guard_in, sticky_in, mant_in[0]);
  assign m_sum  = {1'b0, mant_in} + {{MW{1'b0}}, inc0};
  assign carry  = m_sum[MW];
  assign frac_r = m_sum[FRAC_W-1:0];
  assign e_r    = exp_in + {{(EW-1){1'b0}}, carry};
  assign e_wo   = e_r - WRAP;
  assign e_wu   = e_r + WRAP;

  // tininess after rounding: only exponent zero with an all-ones mantissa can escape
  logic tiny;
  assign tiny = ~((exp_in == ZERO) & inx0 & (&mant_in) &
                  want_inc(rmode, sign_in, guard_in, sticky_in, mant_in[0]));

  // denormalize and round again
  logic signed [EW-1:0] sh_full;
  logic [SHW-1:0] sh;
  logic [2*MW:0] dv;
  logic [MW-1:0] dn_keep, dn_m;
  logic dn_g, dn_s, dn_inx;

  assign sh_full = ONE - exp_in;
  assign sh      = (sh_full > SHLIM) ? SHW'(SHMAX) : sh_full[SHW-1:0];
  assign dv      = {mant_in, {(MW+1){1'b0}}} >> sh;
  assign dn_keep = dv[2*MW:MW+1];
  assign dn_g    = dv[MW];
  assign dn_s    = (|dv[MW-1:0]) | inx0;
  assign dn_inx  = dn_g | dn_s;
  assign dn_m    = dn_keep + {{(MW-1){1'b0}}, want_inc(rmode, sign_in, dn_g, dn_s, dn_keep[0])};

  // range selection
  logic sat_inf;
  assign sat_inf = (rmode == RM_RN) | ((rmode == RM_RP) & ~sign_in) | ((rmode == RM_RM) & sign_in);

  logic [W-1:0] n_res;
  logic n_fo, n_fu, n_inx, n_to, n_tu;

  always_comb begin
    n_res = {sign_in, e_r[EXP_W-1:0], frac_r};
    n_inx = inx0;
    n_fo  = 1'b0;
    n_fu  = 1'b0;
    n_to  = 1'b0;
    n_tu  = 1'b0;
    if (e_r >= EMAX) begin
      if (ovf_trap_en) begin
        n_res = {sign_in, e_wo[EXP_W-1:0], frac_r};
        n_to  = 1'b1;
      end else begin
        n_fo  = 1'b1;
        n_inx = 1'b1;
        n_res = sat_inf ? {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                        : {sign_in, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end
    end else if (e_r <= ZERO) begin
      if (unf_trap_en) begin
        n_res = {sign_in, e_wu[EXP_W-1:0], frac_r};
        n_tu  = 1'b1;
      end else begin
        n_res = {sign_in, {(EXP_W-1){1'b0}}, dn_m};
        n_inx = dn_inx;
        n_fu  = dn_inx & tiny;
      end
    end
  end

  logic [2:0] n_tc;
  assign n_tc = {n_to, n_tu, n_inx & inx_trap_en};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          ovf_flag  <= 1'b0;
          unf_flag  <= 1'b0;
          inx_flag  <= 1'b0;
          trap_code <= '0;
        end else begin
          result    <= n_res;
          ovf_flag  <= n_fo;
          unf_flag  <= n_fu;
          inx_flag  <= n_inx & ~inx_trap_en;
          trap_code <= n_tc;
        end
      end
    end else begin : g_comb
      assign result    = n_res;
      assign ovf_flag  = n_fo;
      assign unf_flag  = n_fu;
      assign inx_flag  = n_inx & ~inx_trap_en;
      assign trap_code = n_tc;
    end
  endgenerate

  // R6
  res_not_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&result[W-2:FRAC_W]) |-> (result[FRAC_W-1:0] == '0));
  // R6
  ovf_reports_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (inx_flag | trap_code[0]));
  // R11
  unf_reports_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (inx_flag | trap_code[0]));
  // R12
  inexact_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inx_flag && trap_code[0]));
  // R7
  ovf_flag_or_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_flag && trap_code[2]));
  // R8
  unf_flag_or_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unf_flag && trap_code[1]));
endmodule

// File: tb/sim_fp_round_range.sv
module sim_fp_round_range;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               sign_in = 1'b0;
  logic signed [13:0] exp_in = '0;
  logic [52:0]        mant_in = '0;
  logic               guard_in = 1'b0, sticky_in = 1'b0;
  logic [1:0]         rmode = 2'd0;
  logic               ovf_trap_en = 1'b0, unf_trap_en = 1'b0, inx_trap_en = 1'b0;
  logic [63:0]        result;
  logic               ovf_flag, unf_flag, inx_flag;
  logic [2:0]         trap_code;

  fp_round_range #(.EXP_W(11), .FRAC_W(52), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sign_in(sign_in), .exp_in(exp_in), .mant_in(mant_in),
    .guard_in(guard_in), .sticky_in(sticky_in), .rmode(rmode),
    .ovf_trap_en(ovf_trap_en), .unf_trap_en(unf_trap_en), .inx_trap_en(inx_trap_en),
    .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .inx_flag(inx_flag),
    .trap_code(trap_code));

  typedef struct packed {
    logic [7:0]  req;
    logic        s;
    logic [13:0] e;
    logic [52:0] m;
    logic        g;
    logic        st;
    logic [1:0]  rm;
    logic [2:0]  te;   // {ovf, unf, inx}
    logic [63:0] res;
    logic [2:0]  fl;   // {ovf, unf, inx}
    logic [2:0]  tc;
  } vec_t;

  localparam int N = 31;
  localparam vec_t TBL [0:N-1] = '{
    '{8'd5,  1'b0, 14'sd1023, 53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b000, 64'h3FF0000000000000, 3'b000, 3'b000}, // R5
    '{8'd2,  1'b0, 14'sd1023, 53'h10000000000000, 1'b1, 1'b0, 2'd1, 3'b000, 64'h3FF0000000000000, 3'b001, 3'b000}, // R2
    '{8'd2,  1'b0, 14'sd1023, 53'h10000000000001, 1'b1, 1'b0, 2'd1, 3'b000, 64'h3FF0000000000002, 3'b001, 3'b000}, // R2
    '{8'd2,  1'b0, 14'sd1023, 53'h10000000000000, 1'b1, 1'b1, 2'd1, 3'b000, 64'h3FF0000000000001, 3'b001, 3'b000}, // R2
    '{8'd1,  1'b0, 14'sd1023, 53'h10000000000001, 1'b1, 1'b1, 2'd0, 3'b000, 64'h3FF0000000000001, 3'b001, 3'b000}, // R1
    '{8'd3,  1'b0, 14'sd1023, 53'h10000000000000, 1'b0, 1'b1, 2'd2, 3'b000, 64'h3FF0000000000001, 3'b001, 3'b000}, // R3
    '{8'd3,  1'b1, 14'sd1023, 53'h10000000000000, 1'b0, 1'b1, 2'd2, 3'b000, 64'hBFF0000000000000, 3'b001, 3'b000}, // R3
    '{8'd3,  1'b1, 14'sd1023, 53'h10000000000000, 1'b0, 1'b1, 2'd3, 3'b000, 64'hBFF0000000000001, 3'b001, 3'b000}, // R3
    '{8'd3,  1'b0, 14'sd1023, 53'h10000000000000, 1'b0, 1'b1, 2'd3, 3'b000, 64'h3FF0000000000000, 3'b001, 3'b000}, // R3
    '{8'd4,  1'b0, 14'sd1023, 53'h1FFFFFFFFFFFFF, 1'b1, 1'b1, 2'd1, 3'b000, 64'h4000000000000000, 3'b001, 3'b000}, // R4
    '{8'd6,  1'b0, 14'sd2047, 53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b000, 64'h7FF0000000000000, 3'b101, 3'b000}, // R6
    '{8'd6,  1'b1, 14'sd3000, 53'h10000000000000, 1'b0, 1'b0, 2'd0, 3'b000, 64'hFFEFFFFFFFFFFFFF, 3'b101, 3'b000}, // R6
    '{8'd6,  1'b1, 14'sd3000, 53'h10000000000000, 1'b0, 1'b0, 2'd2, 3'b000, 64'hFFEFFFFFFFFFFFFF, 3'b101, 3'b000}, // R6
    '{8'd6,  1'b1, 14'sd3000, 53'h10000000000000, 1'b0, 1'b0, 2'd3, 3'b000, 64'hFFF0000000000000, 3'b101, 3'b000}, // R6
    '{8'd6,  1'b0, 14'sd3000, 53'h10000000000000, 1'b0, 1'b0, 2'd3, 3'b000, 64'h7FEFFFFFFFFFFFFF, 3'b101, 3'b000}, // R6
    '{8'd4,  1'b0, 14'sd2046, 53'h1FFFFFFFFFFFFF, 1'b1, 1'b1, 2'd1, 3'b000, 64'h7FF0000000000000, 3'b101, 3'b000}, // R4
    '{8'd7,  1'b0, 14'sd2100, 53'h10000000000000, 1'b0, 1'b0, 2'd0, 3'b100, 64'h2340000000000000, 3'b000, 3'b100}, // R7
    '{8'd7,  1'b0, 14'sd2100, 53'h10000000000000, 1'b1, 1'b0, 2'd0, 3'b100, 64'h2340000000000000, 3'b001, 3'b100}, // R7
    '{8'd12, 1'b0, 14'sd2100, 53'h10000000000000, 1'b1, 1'b0, 2'd0, 3'b101, 64'h2340000000000000, 3'b000, 3'b101}, // R12
    '{8'd8,  1'b0, -14'sd10,  53'h10000000000000, 1'b0, 1'b1, 2'd2, 3'b010, 64'h5F60000000000001, 3'b001, 3'b010}, // R8
    '{8'd11, 1'b0, 14'sd0,    53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b000, 64'h0008000000000000, 3'b000, 3'b000}, // R11
    '{8'd9,  1'b0, 14'sd0,    53'h10000000000001, 1'b0, 1'b0, 2'd1, 3'b000, 64'h0008000000000000, 3'b011, 3'b000}, // R9
    '{8'd9,  1'b0, -14'sd51,  53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b000, 64'h0000000000000001, 3'b000, 3'b000}, // R9
    '{8'd9,  1'b0, -14'sd52,  53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b000, 64'h0000000000000000, 3'b011, 3'b000}, // R9
    '{8'd9,  1'b0, -14'sd52,  53'h10000000000000, 1'b0, 1'b0, 2'd2, 3'b000, 64'h0000000000000001, 3'b011, 3'b000}, // R9
    '{8'd9,  1'b0, -14'sd2000, 53'h10000000000000, 1'b0, 1'b0, 2'd2, 3'b000, 64'h0000000000000001, 3'b011, 3'b000}, // R9
    '{8'd9,  1'b1, -14'sd2000, 53'h10000000000000, 1'b0, 1'b0, 2'd2, 3'b000, 64'h8000000000000000, 3'b011, 3'b000}, // R9
    '{8'd10, 1'b0, 14'sd0,    53'h1FFFFFFFFFFFFF, 1'b1, 1'b0, 2'd1, 3'b000, 64'h0010000000000000, 3'b001, 3'b000}, // R10
    '{8'd10, 1'b0, 14'sd0,    53'h1FFFFFFFFFFFFF, 1'b1, 1'b0, 2'd0, 3'b000, 64'h000FFFFFFFFFFFFF, 3'b011, 3'b000}, // R10
    '{8'd12, 1'b0, 14'sd0,    53'h10000000000001, 1'b0, 1'b0, 2'd1, 3'b001, 64'h0008000000000000, 3'b010, 3'b001}, // R12
    '{8'd12, 1'b0, 14'sd2047, 53'h10000000000000, 1'b0, 1'b0, 2'd1, 3'b001, 64'h7FF0000000000000, 3'b100, 3'b001}  // R12
  };

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: got res=%h fl=%b tc=%b, expected res=%h fl=%b tc=%b",
               tag, act[69:6], act[5:3], act[2:0], exp_v[69:6], exp_v[5:3], exp_v[2:0]);
    end
  endtask

  function automatic logic [69:0] outs();
    return {result, ovf_flag, unf_flag, inx_flag, trap_code};
  endfunction

  task automatic drive(input vec_t v);
    sign_in = v.s; exp_in = v.e; mant_in = v.m; guard_in = v.g; sticky_in = v.st;
    rmode = v.rm; {ovf_trap_en, unf_trap_en, inx_trap_en} = v.te;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset", outs(), 70'd0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      @(posedge clk);
      #2;
      check($sformatf("R%0d vector %0d", TBL[i].req, i), outs(),
            {TBL[i].res, TBL[i].fl, TBL[i].tc});
    end

    // R13 latency: new input not visible before the next edge
    @(negedge clk);
    drive(TBL[0]);
    #1;
    check("R13 hold before edge", outs(), {TBL[N-1].res, TBL[N-1].fl, TBL[N-1].tc});
    @(posedge clk);
    #2;
    check("R13 update after edge", outs(), {TBL[0].res, TBL[0].fl, TBL[0].tc});

    // R13 asynchronous reset clears outputs mid-run
    @(negedge clk);
    drive(TBL[11]);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R13 async clear", outs(), 70'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R6 after reset release", outs(), {TBL[11].res, TBL[11].fl, TBL[11].tc});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule